// File: doc/BRIEF.md
# Multi-Queue Windowed Bit-Rate Meter

This block turns four free-running 32-bit cumulative byte counters, one per packet queue, into bit rates in bits per second. A cycle counter divides time into contiguous windows whose length is a power of ten of clock cycles, chosen by a small select input. At every window boundary each queue's counter is sampled. The byte delta against the previous sample is scaled into a bit rate by a constant multiplier, not a divider. The four rates are then summed, and all five results are published together with a one-cycle valid strobe.

The work after a boundary runs through three states. Increment counts cycles and forms the per-queue rates at the boundary. Sum adds them into the total. Update publishes the results and moves the baseline forward. No cycle carries more than one multiply or one four-way add. A clock-speed select input marks that the core runs at half its nominal 125 MHz, and every rate is then halved. The outputs are plain registers that a register file can sample at any time.

Top module: `qrm_meter`

## Requirements
- R1: While reset is high, all five results read zero, valid is low and the cycle counter is cleared. The counter values present on the last reset cycle become the baseline for the first window.
- R2: A window lasts exactly 10^s clock cycles, where s is the active window select. The boundary falls on the 10^s-th rising edge after reset or after the previous boundary. Valid rises two edges after each boundary.
- R3: For queue q, the rate is (C_end − C_start) × 10^(9−s) bits per second. C_end and C_start are the queue's counter values at two consecutive boundaries. Queue q's counter occupies input bits [32q+31:32q] and its rate occupies output bits [48q+47:48q].
- R4: The byte delta is taken modulo 2^32, so a counter that wraps past its maximum inside a window still yields the true byte count.
- R5: When the half-speed clock select is 1, every per-queue rate is the full-speed value shifted right by one bit (floor of half).
- R6: The total output equals the sum of the four published per-queue rates modulo 2^48.
- R7: Valid is high for exactly one cycle per window. The results change only on the edge that raises valid and hold their values at all other times.
- R8: A change of the window select or the clock select during a window does not alter the length or scaling of that window. It applies from the next boundary on.
- R9: A window select of 0 behaves as 1 (10-cycle window). Selects above 6 behave as 6.
- R10: Each result is 48 bits wide and holds the low 48 bits of the scaled value. The scaled value is the product, halved first when the half-speed select applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_cnt_i | input | 128 | Four cumulative byte counters, queue q in bits [32q+31:32q] |
| win_sel_i | input | 3 | Window exponent s, window = 10^s cycles (valid range 1 to 6) |
| half_clk_i | input | 1 | 1 when the core clock runs at half speed |
| rate_o | output | 192 | Four per-queue bit rates, queue q in bits [48q+47:48q] |
| total_o | output | 48 | Sum of the four per-queue bit rates |
| valid_o | output | 1 | One-cycle strobe marking freshly published results |

## Verification
A boundary falls on the 10^s-th rising edge of a window. The rates taken from the counters sampled on that edge reach the outputs two edges later, the same edge that raises valid. Nothing changes on the outputs in between. The reference model runs in step with the clock, counting edges since reset. At each boundary it queues the expected results with a due edge two cycles ahead. Every cycle it compares valid, all four rates and the total, on the falling edge after that rising edge. A result that is early, late or wrong therefore shows up in the very cycle it differs.

// File: rtl/qrm_pkg.sv
package qrm_pkg;

    // Control sequence of the meter; the order is the processing order.
    typedef enum logic [1:0] {
        ST_INC = 2'd0,
        ST_SUM = 2'd1,
        ST_UPD = 2'd2
    } qrm_state_e;

    // Nanoseconds per second expressed as a power of ten.
    localparam int NS_EXP = 9;

    // Integer power of ten, used for constant tables and widths.
    function automatic longint unsigned pow10(input int n);
        longint unsigned p;
        p = 1;
        for (int i = 0; i < n; i++) begin
            p = p * 10;
        end
        return p;
    endfunction

endpackage

// File: rtl/qrm_window_timer.sv
module qrm_window_timer
    import qrm_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter int MIN_EXP = 1,
    parameter int MAX_EXP = 6,
    parameter int LIM_W   = 20,
    parameter int MULT_W  = 27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  win_sel_i,
    input  logic              half_i,
    output logic              tick_o,
    output logic [MULT_W-1:0] mult_o,
    output logic              half_o
);

    localparam int NEXP  = MAX_EXP - MIN_EXP + 1;
    localparam int IDX_W = (NEXP > 1) ? $clog2(NEXP) : 1;

    logic [LIM_W-1:0]  lim_tab [NEXP];
    logic [MULT_W-1:0] mul_tab [NEXP];

    // Last cycle index of each window and the matching bit-rate scale.
    for (genvar g = 0; g < NEXP; g++) begin : g_tab
        assign lim_tab[g] = LIM_W'(pow10(MIN_EXP + g) - 1);
        assign mul_tab[g] = MULT_W'(pow10(NS_EXP - MIN_EXP - g));
    end

    logic [SEL_W-1:0] sel_c;
    logic [IDX_W-1:0] idx_c;

    always_comb begin
        if (int'(win_sel_i) < MIN_EXP) begin
            sel_c = SEL_W'(MIN_EXP);
        end else if (int'(win_sel_i) > MAX_EXP) begin
            sel_c = SEL_W'(MAX_EXP);
        end else begin
            sel_c = win_sel_i;
        end
        idx_c = IDX_W'(sel_c - SEL_W'(MIN_EXP));
    end

    logic [LIM_W-1:0]  cnt_q;
    logic [LIM_W-1:0]  lim_q;
    logic [MULT_W-1:0] mult_q;
    logic              half_q;

    assign tick_o = (cnt_q == lim_q);
    assign mult_o = mult_q;
    assign half_o = half_q;

    // Configuration is sampled only at reset and on the boundary cycle,
    // so the running window keeps its length and scale.
    always_ff @(posedge clk) begin
        if (rst || tick_o) begin
            cnt_q  <= '0;
            lim_q  <= lim_tab[idx_c];
            mult_q <= mul_tab[idx_c];
            half_q <= half_i;
        end else begin
            cnt_q  <= cnt_q + LIM_W'(1);
        end
    end

endmodule

// File: rtl/qrm_rate_lane.sv
module qrm_rate_lane #(
    parameter int CNT_W  = 32,
    parameter int RATE_W = 48,
    parameter int MULT_W = 27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              capture_i,
    input  logic              commit_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic              half_i,
    output logic [RATE_W-1:0] rate_o
);

    // One spare bit above the result keeps the halved value exact.
    localparam int PW = RATE_W + 1;

    logic [CNT_W-1:0]  base_q;
    logic [CNT_W-1:0]  snap_q;
    logic [RATE_W-1:0] rate_q;
    logic [CNT_W-1:0]  delta;
    logic [PW-1:0]     prod;

    // Modulo subtraction absorbs a counter wrap inside the window.
    assign delta  = cnt_i - base_q;
    assign prod   = PW'(delta) * PW'(mult_i);
    assign rate_o = rate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= cnt_i;
            snap_q <= cnt_i;
            rate_q <= '0;
        end else begin
            if (capture_i) begin
                snap_q <= cnt_i;
                rate_q <= half_i ? prod[RATE_W:1] : prod[RATE_W-1:0];
            end
            if (commit_i) begin
                base_q <= snap_q;
            end
        end
    end

endmodule

// File: rtl/qrm_meter.sv
module qrm_meter
    import qrm_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int CNT_W   = 32,
    parameter int RATE_W  = 48,
    parameter int SEL_W   = 3,
    parameter int MIN_EXP = 1,
    parameter int MAX_EXP = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NQ*CNT_W-1:0]    byte_cnt_i,
    input  logic [SEL_W-1:0]       win_sel_i,
    input  logic                   half_clk_i,
    output logic [NQ*RATE_W-1:0]   rate_o,
    output logic [RATE_W-1:0]      total_o,
    output logic                   valid_o
);

    localparam int LIM_W  = $clog2(pow10(MAX_EXP));
    localparam int MULT_W = $clog2(pow10(NS_EXP - MIN_EXP) + 1);

    qrm_state_e        state_q;
    logic              tick;
    logic [MULT_W-1:0] mult;
    logic              half_act;
    logic [RATE_W-1:0] lane_rate [NQ];
    logic [RATE_W-1:0] sum_c;
    logic [RATE_W-1:0] total_w_q;
    logic [NQ*RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] total_q;
    logic              valid_q;

    qrm_window_timer #(
        .SEL_W   (SEL_W),
        .MIN_EXP (MIN_EXP),
        .MAX_EXP (MAX_EXP),
        .LIM_W   (LIM_W),
        .MULT_W  (MULT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .win_sel_i (win_sel_i),
        .half_i    (half_clk_i),
        .tick_o    (tick),
        .mult_o    (mult),
        .half_o    (half_act)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_lane
        qrm_rate_lane #(
            .CNT_W  (CNT_W),
            .RATE_W (RATE_W),
            .MULT_W (MULT_W)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .cnt_i     (byte_cnt_i[g*CNT_W +: CNT_W]),
            .capture_i (tick),
            .commit_i  (state_q == ST_UPD),
            .mult_i    (mult),
            .half_i    (half_act),
            .rate_o    (lane_rate[g])
        );
    end

    always_comb begin
        sum_c = '0;
        for (int q = 0; q < NQ; q++) begin
            sum_c = sum_c + lane_rate[q];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_INC;
            total_w_q <= '0;
            rate_q    <= '0;
            total_q   <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_INC: begin
                    if (tick) begin
                        state_q <= ST_SUM;
                    end
                end
                ST_SUM: begin
                    total_w_q <= sum_c;
                    state_q   <= ST_UPD;
                end
                ST_UPD: begin
                    for (int q = 0; q < NQ; q++) begin
                        rate_q[q*RATE_W +: RATE_W] <= lane_rate[q];
                    end
                    total_q <= total_w_q;
                    valid_q <= 1'b1;
                    state_q <= ST_INC;
                end
                default: state_q <= ST_INC;
            endcase
        end
    end

    assign rate_o  = rate_q;
    assign total_o = total_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/qrm_checker.sv
module qrm_checker
    import qrm_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int RATE_W = 48
) (
    input logic                 clk,
    input logic                 rst,
    input qrm_state_e           state,
    input logic                 tick,
    input logic [NQ*RATE_W-1:0] rate_o,
    input logic [RATE_W-1:0]    total_o,
    input logic                 valid_o
);

    logic [RATE_W-1:0] lane_sum;

    always_comb begin
        lane_sum = '0;
        for (int q = 0; q < NQ; q++) begin
            lane_sum = lane_sum + rate_o[q*RATE_W +: RATE_W];
        end
    end

    // R7: the strobe never lasts two cycles
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7: results hold while no strobe is raised
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(rate_o) && $stable(total_o)));

    // R6: the published total matches the published lanes
    p_total_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (total_o == lane_sum));

    // R2: a boundary is only seen in the counting state
    p_tick_state_r2: assert property (@(posedge clk) disable iff (rst)
        tick |-> (state == ST_INC));

    // R2: summing follows a boundary directly
    p_sum_after_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUM) |-> $past(tick));

    // R2: valid follows the update state
    p_valid_after_upd_r2: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($past(state) == ST_UPD));

endmodule

bind qrm_meter qrm_checker #(
    .NQ     (NQ),
    .RATE_W (RATE_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .state   (state_q),
    .tick    (tick),
    .rate_o  (rate_o),
    .total_o (total_o),
    .valid_o (valid_o)
);

// File: tb/qrm_meter_bench.sv
module qrm_meter_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] byte_cnt;
    logic [2:0]   win_sel = 3'd1;
    logic         half_clk = 1'b0;
    logic [191:0] rate;
    logic [47:0]  total;
    logic         valid;

    logic [31:0] qc [4];
    logic [31:0] st [4];

    assign byte_cnt = {qc[3], qc[2], qc[1], qc[0]};

    always #4 clk = ~clk;

    qrm_meter u_qrm_meter (
        .clk        (clk),
        .rst        (rst),
        .byte_cnt_i (byte_cnt),
        .win_sel_i  (win_sel),
        .half_clk_i (half_clk),
        .rate_o     (rate),
        .total_o    (total),
        .valid_o    (valid)
    );

    // ---------------- reference model ----------------
    typedef struct packed {
        int               due;
        logic [3:0][47:0] r;
    } result_t;

    result_t     pend [$];
    int          m_t;
    int          m_cnt;
    int          m_exp;
    bit          m_half;
    logic [31:0] m_base [4];
    logic [3:0][47:0] exp_rate;
    logic [47:0] exp_total;
    bit          exp_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    function automatic longint unsigned ten_to(input int n);
        longint unsigned v = 1;
        for (int i = 0; i < n; i++) v = v * 10;
        return v;
    endfunction

    function automatic int clamp_sel(input logic [2:0] w);
        int v = int'(w);
        if (v < 1) v = 1;
        if (v > 6) v = 6;
        return v;
    endfunction

    // Predicts what the next rising edge does, from the inputs now driven.
    task automatic model_step();
        if (rst) begin
            m_t = 0;
            m_cnt = 0;
            m_exp = clamp_sel(win_sel);
            m_half = half_clk;
            for (int q = 0; q < 4; q++) m_base[q] = qc[q];
            pend.delete();
            exp_rate = '0;
            exp_total = '0;
            exp_valid = 1'b0;
            return;
        end
        m_t++;
        exp_valid = 1'b0;
        if (pend.size() > 0 && pend[0].due == m_t) begin
            result_t e = pend.pop_front();
            exp_rate = e.r;
            exp_total = '0;
            for (int q = 0; q < 4; q++) exp_total = exp_total + e.r[q];
            exp_valid = 1'b1;
        end
        if (longint'(m_cnt) == longint'(ten_to(m_exp)) - 1) begin
            result_t n;
            n.due = m_t + 2;
            for (int q = 0; q < 4; q++) begin
                logic [31:0] d = qc[q] - m_base[q];
                longint unsigned p = longint'(d) * ten_to(9 - m_exp);
                if (m_half) p = p >> 1;
                n.r[q] = p[47:0];
                m_base[q] = qc[q];
            end
            pend.push_back(n);
            m_cnt = 0;
            m_exp = clamp_sel(win_sel);
            m_half = half_clk;
        end else begin
            m_cnt++;
        end
    endtask

    task automatic compare();
        checks++;
        if (valid !== exp_valid || total !== exp_total || rate !== exp_rate) begin
            errors++;
            $display("FAIL %s t=%0d valid=%0b exp=%0b total=%0h exp=%0h rate=%0h exp=%0h",
                     cur_req, m_t, valid, exp_valid, total, exp_total, rate, exp_rate);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(negedge clk);
            compare();
            for (int q = 0; q < 4; q++) qc[q] = qc[q] + st[q];
        end
    endtask

    task automatic set_steps(input logic [31:0] a, b, c, d);
        st[0] = a; st[1] = b; st[2] = c; st[3] = d;
    endtask

    initial begin
        qc[0] = 32'd100; qc[1] = 32'd2000; qc[2] = 32'd30000; qc[3] = 32'd400000;
        set_steps(1, 2, 3, 4);
        @(negedge clk);

        // R1: reset clears results and captures the baseline
        cur_req = "R1";
        run(3);
        rst = 1'b0;

        // R2 R3 R6 R7: ten-cycle windows with distinct per-queue traffic
        cur_req = "R3";
        set_steps(5, 17, 64, 1);
        run(45);

        // R8: select changes in mid-window, old length finishes first
        cur_req = "R8";
        win_sel = 3'd2;
        set_steps(3, 0, 9, 250);
        run(250);

        // R5: half-speed clock halves every rate, odd values floor
        cur_req = "R5";
        half_clk = 1'b1;
        set_steps(7, 13, 1, 255);
        run(250);

        // R4: counters wrap past their maximum inside a window
        cur_req = "R4";
        half_clk = 1'b0;
        win_sel = 3'd1;
        run(12);
        qc[0] = 32'hFFFF_FFF0; qc[1] = 32'hFFFF_FFFA; qc[2] = 32'hFFFF_FF00; qc[3] = 32'd5;
        set_steps(3, 1, 40, 1);
        run(60);

        // R9: select 0 behaves as a ten-cycle window
        cur_req = "R9";
        win_sel = 3'd0;
        set_steps(11, 22, 33, 44);
        run(45);

        // R10: large deltas whose scaled value exceeds 48 bits
        cur_req = "R10";
        win_sel = 3'd3;
        set_steps(32'h0FFF_FFFF, 32'h0123_4567, 32'h7000_0001, 32'd9);
        run(2100);

        // R1: reset mid-window recaptures the baseline
        cur_req = "R1";
        rst = 1'b1;
        qc[0] = 32'd7; qc[1] = 32'hABCD_0000; qc[2] = 32'd0; qc[3] = 32'hFFFF_FFFF;
        set_steps(2, 3, 5, 7);
        win_sel = 3'd4;
        run(2);
        rst = 1'b0;

        // R2: ten-thousand-cycle window length and strobe timing
        cur_req = "R2";
        run(10050);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule